// File: doc/BRIEF.md
# Triggerable Variable-Period Cycle Generator

This block produces a stream of cycle-start strobes for the timing logic around it. Each cycle lasts a number of clocks taken from a period word. The word is read only at the moment a cycle begins, and it is saturated between a programmable floor and a programmable ceiling. With no other input active, the generator runs freely and issues one strobe per period. A busy flag reports that a cycle is in progress.

Two control inputs change this free-running behaviour. A hold input lets the cycle in progress run to its end and then keeps the generator idle until hold drops. An asynchronous trigger input is synchronized, and its rising edge cuts the running cycle short and starts a new one at once. Hold outranks trigger: a trigger edge that arrives while hold is high is stored, and it starts a cycle as soon as hold is released. A lockout input, driven from supply supervision, keeps the generator in its reset state for as long as it is high.

Top module: `vp_cycle_gen`

## Requirements
- R1: With hold_i, trig_i and lockout_i low, start_o pulses once every L clocks, where L is the clamped period. busy_o is high on every clock of the cycle.
- R2: The period inputs are sampled only on the clock in which a cycle starts. A change made during a cycle takes effect from the next cycle.
- R3: L is computed in three steps. First, period_i is limited to at most max_len_i. Second, the result is raised to at least min_len_i, so the minimum wins when the minimum exceeds the maximum. Third, the result is raised to at least 2.
- R4: start_o is never high on two consecutive clocks. busy_o is high whenever start_o is high. A trigger edge that falls on the clock of a strobe is kept, and it produces the next strobe two clocks after that strobe.
- R5: If hold_i rises during a cycle, busy_o stays high until that cycle's L clocks have elapsed and then falls. No strobe is issued while hold_i is high.
- R6: If trig_i is sampled high at clock edge a, after having been low, then the running cycle is abandoned and start_o is high in the clock after edge a+2. This is the third rising edge that sees trig_i high.
- R7: A trigger pulse of any length causes one restart only. The cycle after the restart lasts the full L clocks.
- R8: A trigger edge that arrives while hold_i is high starts no cycle. It is stored, and start_o is high in the clock after the first edge at which hold_i is sampled low.
- R9: A stored trigger is cleared when the cycle it caused begins. The following cycle lasts the full L clocks.
- R10: While lockout_i is high, start_o and busy_o are low one clock later and stay low. When lockout_i falls, the generator resumes as if it had just been reset.
- R11: When the generator is idle and hold_i and lockout_i are low, start_o is high in the next clock. This also applies to the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lockout_i | input | 1 | Supply lockout; holds the generator in reset while high |
| hold_i | input | 1 | Finish the current cycle, then start no new cycle |
| trig_i | input | 1 | Asynchronous trigger; its rising edge restarts the cycle |
| period_i | input | PERIOD_W | Requested cycle length in clocks |
| min_len_i | input | PERIOD_W | Lower saturation limit of the cycle length |
| max_len_i | input | PERIOD_W | Upper saturation limit of the cycle length |
| start_o | output | 1 | One-clock strobe at the start of each cycle |
| busy_o | output | 1 | High while a cycle is in progress |

## Verification
The hardest situation to reach is a trigger that arrives while hold is high and a cycle is still running, with hold released before that cycle ends. Only then does the stored trigger decide the outcome, because the cycle is cut short rather than a fresh idle start occurring. A second hard case is a synchronized trigger edge that lands exactly on a strobe clock. The stimulus reaches both situations by aligning to an observed strobe and then counting clocks before it raises hold or trigger. For the strobe collision, the trigger is raised two clocks before the next strobe is due. Randomized period, floor and ceiling words, each measured over a whole cycle, cover the saturation rules.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int unsigned CG_LEN_FLOOR = 2;

  typedef enum logic {
    CG_IDLE = 1'b0,
    CG_RUN  = 1'b1
  } cg_state_e;
endpackage

// File: rtl/cg_trig_sync.sv
module cg_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cg_period_clamp.sv
module cg_period_clamp #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] len_o
);
  import cg_pkg::*;
  localparam logic [W-1:0] FLOOR = W'(CG_LEN_FLOOR);

  logic [W-1:0] cap, lift;

  always_comb begin
    cap   = (period_i > max_i) ? max_i : period_i;
    lift  = (cap < min_i) ? min_i : cap;
    len_o = (lift < FLOOR) ? FLOOR : lift;
  end
endmodule

// File: rtl/cg_cycle_core.sv
module cg_cycle_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lockout_i,
  input  logic         hold_i,
  input  logic         edge_i,
  input  logic [W-1:0] len_i,
  output logic         start_o,
  output logic         busy_o
);
  import cg_pkg::*;

  cg_state_e    state_q;
  logic [W-1:0] cnt_q;
  logic         start_q;
  logic         pend_q;
  logic         expire, want_trig, go;

  // a trigger colliding with a strobe is deferred through pend_q
  assign expire    = (state_q == CG_RUN) && (cnt_q == W'(1));
  assign want_trig = (edge_i | pend_q) & ~start_q;
  assign go        = ~hold_i & ((state_q == CG_IDLE) | expire | want_trig);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CG_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (lockout_i) begin
      state_q <= CG_IDLE;
      cnt_q   <= '0;
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      start_q <= go;
      if (go) begin
        state_q <= CG_RUN;
        cnt_q   <= len_i;
        pend_q  <= 1'b0;
      end else begin
        if (edge_i) pend_q <= 1'b1;
        if (expire) state_q <= CG_IDLE;
        else if (state_q == CG_RUN) cnt_q <= cnt_q - W'(1);
      end
    end
  end

  assign start_o = start_q;
  assign busy_o  = (state_q == CG_RUN);
endmodule

// File: rtl/vp_cycle_gen.sv
module vp_cycle_gen #(
  parameter int unsigned PERIOD_W    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lockout_i,
  input  logic                hold_i,
  input  logic                trig_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [PERIOD_W-1:0] min_len_i,
  input  logic [PERIOD_W-1:0] max_len_i,
  output logic                start_o,
  output logic                busy_o
);
  logic                trig_edge;
  logic [PERIOD_W-1:0] cyc_len;

  cg_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  cg_period_clamp #(.W(PERIOD_W)) u_clamp (
    .period_i (period_i),
    .min_i    (min_len_i),
    .max_i    (max_len_i),
    .len_o    (cyc_len)
  );

  cg_cycle_core #(.W(PERIOD_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lockout_i (lockout_i),
    .hold_i    (hold_i),
    .edge_i    (trig_edge),
    .len_i     (cyc_len),
    .start_o   (start_o),
    .busy_o    (busy_o)
  );
endmodule

// File: rtl/vp_cycle_gen_chk.sv
module vp_cycle_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lockout_i,
  input logic hold_i,
  input logic start_o,
  input logic busy_o
);
  a_r4_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r4_busy_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  a_r5_hold_blocks_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !start_o);

  a_r10_lockout_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> (!start_o && !busy_o));

  a_r11_idle_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !hold_i && !lockout_i) |=> start_o);
endmodule

bind vp_cycle_gen vp_cycle_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lockout_i (lockout_i),
  .hold_i    (hold_i),
  .start_o   (start_o),
  .busy_o    (busy_o)
);

// File: tb/sim_vp_cycle_gen.sv
`timescale 1ns/1ps
module sim_vp_cycle_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         lockout_i = 1'b0;
  logic         hold_i = 1'b0;
  logic         trig_i = 1'b0;
  logic [W-1:0] period_i = 8'd10;
  logic [W-1:0] min_len_i = 8'd4;
  logic [W-1:0] max_len_i = 8'd40;
  logic         start_o, busy_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vp_cycle_gen #(.PERIOD_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lockout_i(lockout_i), .hold_i(hold_i),
    .trig_i(trig_i), .period_i(period_i), .min_len_i(min_len_i),
    .max_len_i(max_len_i), .start_o(start_o), .busy_o(busy_o)
  );

  function automatic int exp_len(int p, int mn, int mx);
    int t;
    t = (p > mx) ? mx : p;
    t = (t < mn) ? mn : t;
    if (t < 2) t = 2;
    return t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic sync_start();
    int n = 0;
    do begin @(negedge clk); n++; end while (!start_o && n < 2000);
  endtask

  task automatic gap(output int n, output bit all_busy);
    n = 0; all_busy = 1'b1;
    do begin
      @(negedge clk); n++;
      if (!busy_o) all_busy = 1'b0;
    end while (!start_o && n < 2000);
  endtask

  task automatic set_len(int p, int mn, int mx);
    period_i = W'(p); min_len_i = W'(mn); max_len_i = W'(mx);
  endtask

  initial begin
    int g, k, k1, k2, e;
    bit b, seen;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    check(start_o == 1'b0 && busy_o == 1'b0, "reset R10", {start_o, busy_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(start_o == 1'b1, "R11 first start after reset", start_o, 1);

    // R1 free run, R2 period sampled at start
    gap(g, b);
    check(g == 10, "R1 free-run period", g, 10);
    check(b, "R1 busy through cycle", b, 1);
    period_i = 8'd20;
    gap(g, b);
    check(g == 10, "R2 mid-cycle change deferred", g, 10);
    gap(g, b);
    check(g == 20, "R2 new period applied", g, 20);

    // R3 saturation corners
    set_len(2, 6, 40);   sync_start(); gap(g, b);
    check(g == 6, "R3 floor limit", g, 6);
    set_len(100, 4, 40); sync_start(); gap(g, b);
    check(g == 40, "R3 ceiling limit", g, 40);
    set_len(25, 30, 20); sync_start(); gap(g, b);
    check(g == 30, "R3 min wins over max", g, 30);
    set_len(0, 0, 0);    sync_start(); gap(g, b);
    check(g == 2, "R3 absolute floor of 2", g, 2);

    // R5 hold mid-cycle
    set_len(12, 4, 40); sync_start(); sync_start();
    repeat (4) @(negedge clk);
    hold_i = 1'b1;
    k = 0; seen = 1'b0;
    do begin @(negedge clk); k++; if (start_o) seen = 1'b1; end while (busy_o && k < 100);
    check(k == 8, "R5 cycle completes under hold", k, 8);
    repeat (20) begin @(negedge clk); if (start_o || busy_o) seen = 1'b1; end
    check(!seen, "R5 no strobe while held", seen, 0);
    hold_i = 1'b0;
    @(negedge clk);
    check(start_o == 1'b1, "R11 restart on hold release", start_o, 1);

    // R6 trigger abort, R7 single restart
    set_len(30, 4, 40); sync_start(); sync_start();
    repeat (5) @(negedge clk);
    trig_i = 1'b1; k = 0;
    do begin @(negedge clk); k++; if (k == 2) trig_i = 1'b0; end while (!start_o && k < 100);
    check(k == 3, "R6 trigger latency", k, 3);
    gap(g, b);
    check(g == 30, "R7 full cycle after short pulse", g, 30);
    repeat (5) @(negedge clk);
    trig_i = 1'b1; k = 0;
    do begin @(negedge clk); k++; end while (!start_o && k < 100);
    check(k == 3, "R6 long pulse latency", k, 3);
    gap(g, b);
    check(g == 30, "R7 long pulse counts once", g, 30);
    trig_i = 1'b0;

    // R4 trigger edge lands on strobe clock
    sync_start();
    repeat (28) @(negedge clk);
    trig_i = 1'b1; k = 0; k1 = 0; k2 = 0;
    do begin
      @(negedge clk); k++;
      if (k == 2) trig_i = 1'b0;
      if (start_o) begin if (k1 == 0) k1 = k; else k2 = k; end
    end while (k2 == 0 && k < 100);
    check(k1 == 2, "R4 normal strobe kept", k1, 2);
    check(k2 == 4, "R4 deferred trigger strobe", k2, 4);

    // R8 stored trigger under hold, R9 cleared on use
    sync_start();
    repeat (3) @(negedge clk);
    hold_i = 1'b1;
    repeat (2) @(negedge clk);
    trig_i = 1'b1;
    seen = 1'b0;
    repeat (2) begin @(negedge clk); if (start_o) seen = 1'b1; end
    trig_i = 1'b0;
    repeat (4) begin @(negedge clk); if (start_o) seen = 1'b1; end
    check(!seen && busy_o, "R8 trigger held off", {seen, busy_o}, 1);
    hold_i = 1'b0;
    @(negedge clk);
    check(start_o == 1'b1, "R8 stored trigger fires on release", start_o, 1);
    gap(g, b);
    check(g == 30, "R9 stored trigger cleared", g, 30);

    // R10 lockout
    hold_i = 1'b1;
    trig_i = 1'b1; repeat (2) @(negedge clk); trig_i = 1'b0;
    lockout_i = 1'b1;
    seen = 1'b0;
    repeat (5) begin @(negedge clk); if (start_o || busy_o) seen = 1'b1; end
    check(!seen, "R10 quiet under lockout", seen, 0);
    lockout_i = 1'b0;
    repeat (10) begin @(negedge clk); if (start_o || busy_o) seen = 1'b1; end
    check(!seen, "R10 held idle after lockout", seen, 0);
    hold_i = 1'b0;
    @(negedge clk);
    check(start_o == 1'b1, "R11 start after hold release", start_o, 1);
    repeat (3) @(negedge clk);
    lockout_i = 1'b1;
    @(negedge clk);
    check(!start_o && !busy_o, "R10 lockout stops running cycle", {start_o, busy_o}, 0);
    lockout_i = 1'b0;
    @(negedge clk);
    check(start_o == 1'b1, "R10 resume after lockout", start_o, 1);

    // R1/R3 random periods and limits
    for (int i = 0; i < 40; i++) begin
      int p, mn, mx;
      p  = int'($urandom_range(0, 80));
      mn = int'($urandom_range(0, 12));
      mx = int'($urandom_range(8, 60));
      set_len(p, mn, mx);
      sync_start();
      gap(g, b);
      e = exp_len(p, mn, mx);
      check(g == e && b, "R3 random clamp R1 period", g, e);
    end

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
      $finish;
    end
  end
endmodule